// File: doc/BRIEF.md
# Interleaved Reed-Solomon Frame Encoder

This block forms one 108-bit link frame on every word-clock cycle in which its enable is high. Each word brings 64 data bits, 8 trigger bits and a 4-bit header. The 72 user bits are first passed through a self-synchronizing polynomial scrambler, which removes long runs and low-frequency content from the line. The scrambled bits are then split into two interleaved codewords, and each codeword gets four parity symbols over GF(16). The frame is registered, so it appears one cycle after its inputs and is ready for a downstream serializer.

Each codeword is a shortened RS(15,11) code with 4-bit symbols: 9 information symbols, with the two leading positions implied zero, plus 4 parity symbols. The code is systematic, so the scrambled user symbols appear unchanged in the frame. The header is not coded and takes the top four bits of the frame.

Top module: `rs_frame_encoder`

## Requirements
- R1: While rst_n is low, and after it is released until the first enabled word, frame_out is all zero and frame_vld is 0.
- R2: frame_vld is 1 in the cycle after a cycle with word_en high, and 0 in the cycle after a cycle with word_en low. A frame sampled on an enabled edge is on frame_out right after that edge, so the latency is one cycle.
- R3: frame_out[107:104] equals the hdr_in of the enabled word, passed through unchanged.
- R4: frame_out[103:32] is the scrambled form of the user word u = {data_in, trig_in}. The bits are processed from u[71] down to u[0], and each output bit is s = d XOR (the output bit 39 places earlier) XOR (the output bit 58 places earlier). The history carries across frames. After reset, the bit k+1 places before the first processed bit is SEED[k].
- R5: The user field holds 18 four-bit symbols. Symbol j (j = 0..17) sits at frame_out[103-4j -: 4]. It belongs to codeword j mod 2, at information position j/2, where position 0 has the highest degree (12).
- R6: Parity symbol q (q = 0..7) sits at frame_out[31-4q -: 4]. It belongs to codeword q mod 2, at degree 3 - q/2. Treat each codeword as a polynomial over GF(16) built on x^4 + x + 1, with symbol bit 3 as the coefficient of x^3. That polynomial is zero at alpha^1, alpha^2, alpha^3 and alpha^4, where alpha = 4'b0010.
- R7: A cycle with word_en low changes neither frame_out nor the scrambler history. The next enabled frame continues the scrambled stream as if the idle cycles had not happened.
- R8: Asserting rst_n in the middle of a stream restarts the scrambler history at SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| word_en | input | 1 | Accepts the current word and advances the scrambler |
| data_in | input | 64 | Data bits of the word |
| trig_in | input | 8 | Trigger bits of the word |
| hdr_in | input | 4 | Uncoded header |
| frame_out | output | 108 | Registered frame: header, interleaved user symbols, interleaved parity |
| frame_vld | output | 1 | frame_out was loaded on the last edge |

## Verification
The bench builds the block with its default widths: 64 data bits, 8 trigger bits, a 4-bit header, two codewords of four parity symbols, and a 58/39 scrambler. This gives exactly the 108-bit frame and the two-way symbol interleave. It overrides SEED with an irregular pattern, so the history left from reset visibly shapes the first frame, and so the restart after a mid-stream reset can be told apart from a stream that simply continues. Parity is judged by evaluating each de-interleaved codeword at the four roots, and the user field is judged by a bit-serial scrambler model. Either check catches a misplaced symbol, a wrong generator or a wrong tap.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;
  localparam int SYM_W    = 4;
  localparam int GF_ORDER = (1 << SYM_W) - 1;
  // low bits of the field polynomial x^4 + x + 1
  localparam logic [SYM_W-1:0] GF_POLY_LOW = 4'b0011;

  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? GF_POLY_LOW : sym_t'(0));
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(int e);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < (e % GF_ORDER); i++) r = gf_mul(r, sym_t'(2));
    return r;
  endfunction
endpackage

// File: rtl/rsenc_scrambler.sv
module rsenc_scrambler
  import rsenc_pkg::*;
#(
  parameter int                  USER_W  = 72,
  parameter int                  SCR_LEN = 58,
  parameter int                  SCR_TAP = 39,
  parameter logic [SCR_LEN-1:0]  SEED    = 58'h155_5555_5555_5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [USER_W-1:0] user_i,
  output logic [USER_W-1:0] scr_o
);
  // hist_q[k] is the scrambled bit emitted k+1 places ago
  logic [SCR_LEN-1:0] hist_q;
  logic [SCR_LEN-1:0] hist_d;

  always_comb begin
    logic [SCR_LEN-1:0] h;
    logic               s;
    h     = hist_q;
    scr_o = '0;
    for (int b = USER_W - 1; b >= 0; b--) begin
      s        = user_i[b] ^ h[SCR_TAP-1] ^ h[SCR_LEN-1];
      scr_o[b] = s;
      h        = {h[SCR_LEN-2:0], s};
    end
    hist_d = h;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= SEED;
    else if (en_i) hist_q <= hist_d;
  end

  p_history_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(hist_q))
    else $error("scrambler history moved while idle");

  p_seed_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hist_q == SEED))
    else $error("scrambler did not restart at seed");
endmodule

// File: rtl/rsenc_parity.sv
module rsenc_parity
  import rsenc_pkg::*;
#(
  parameter int INFO_SYM = 9,
  parameter int PAR_SYM  = 4
) (
  input  logic [INFO_SYM*SYM_W-1:0] msg_i,
  output logic [PAR_SYM*SYM_W-1:0]  par_o
);
  // generator: product of (x + alpha^i), i = 1..PAR_SYM, leading 1 implied
  function automatic logic [PAR_SYM*SYM_W-1:0] gen_poly();
    sym_t                      c [PAR_SYM+1];
    sym_t                      r;
    logic [PAR_SYM*SYM_W-1:0]  g;
    for (int k = 0; k <= PAR_SYM; k++) c[k] = '0;
    c[0] = sym_t'(1);
    for (int i = 1; i <= PAR_SYM; i++) begin
      r = gf_alpha_pow(i);
      for (int k = i; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(r, c[k]);
      c[0] = gf_mul(r, c[0]);
    end
    for (int k = 0; k < PAR_SYM; k++) g[k*SYM_W +: SYM_W] = c[k];
    return g;
  endfunction

  localparam logic [PAR_SYM*SYM_W-1:0] GEN = gen_poly();

  // unrolled polynomial division, highest-degree symbol first
  always_comb begin
    sym_t rem [PAR_SYM];
    sym_t fb;
    for (int k = 0; k < PAR_SYM; k++) rem[k] = '0;
    for (int i = INFO_SYM - 1; i >= 0; i--) begin
      fb = msg_i[i*SYM_W +: SYM_W] ^ rem[PAR_SYM-1];
      for (int k = PAR_SYM - 1; k >= 1; k--)
        rem[k] = rem[k-1] ^ gf_mul(fb, GEN[k*SYM_W +: SYM_W]);
      rem[0] = gf_mul(fb, GEN[0 +: SYM_W]);
    end
    for (int k = 0; k < PAR_SYM; k++) par_o[k*SYM_W +: SYM_W] = rem[k];
  end

  // Horner evaluation of the whole codeword at a root
  function automatic sym_t cw_eval(int root, logic [INFO_SYM*SYM_W-1:0] m,
                                   logic [PAR_SYM*SYM_W-1:0] p);
    sym_t acc;
    sym_t x;
    acc = '0;
    x   = gf_alpha_pow(root);
    for (int i = INFO_SYM - 1; i >= 0; i--) acc = gf_mul(acc, x) ^ m[i*SYM_W +: SYM_W];
    for (int k = PAR_SYM - 1; k >= 0; k--)  acc = gf_mul(acc, x) ^ p[k*SYM_W +: SYM_W];
    return acc;
  endfunction

  always_comb begin
    if (!$isunknown({msg_i, par_o})) begin
      for (int i = 1; i <= PAR_SYM; i++) begin
        p_codeword_root_r6: assert (cw_eval(i, msg_i, par_o) == '0)
          else $error("codeword not zero at alpha^%0d", i);
      end
    end
  end
endmodule

// File: rtl/rs_frame_encoder.sv
module rs_frame_encoder
  import rsenc_pkg::*;
#(
  parameter int                 DATA_W  = 64,
  parameter int                 TRIG_W  = 8,
  parameter int                 HDR_W   = 4,
  parameter int                 N_CW    = 2,
  parameter int                 PAR_SYM = 4,
  parameter int                 SCR_LEN = 58,
  parameter int                 SCR_TAP = 39,
  parameter logic [SCR_LEN-1:0] SEED    = 58'h155_5555_5555_5555
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                word_en,
  input  logic [DATA_W-1:0]                                   data_in,
  input  logic [TRIG_W-1:0]                                   trig_in,
  input  logic [HDR_W-1:0]                                    hdr_in,
  output logic [HDR_W+DATA_W+TRIG_W+N_CW*PAR_SYM*SYM_W-1:0]   frame_out,
  output logic                                                frame_vld
);
  localparam int USER_W   = DATA_W + TRIG_W;
  localparam int USER_SYM = USER_W / SYM_W;
  localparam int INFO_SYM = USER_SYM / N_CW;
  localparam int PAR_TOT  = N_CW * PAR_SYM;
  localparam int PAR_W    = PAR_TOT * SYM_W;
  localparam int FRAME_W  = HDR_W + USER_W + PAR_W;

  logic [USER_W-1:0]         user_scr;
  logic [INFO_SYM*SYM_W-1:0] cw_msg [N_CW];
  logic [PAR_SYM*SYM_W-1:0]  cw_par [N_CW];
  logic [PAR_W-1:0]          par_field;
  logic [FRAME_W-1:0]        frame_d;
  logic [FRAME_W-1:0]        frame_q;
  logic                      vld_q;

  rsenc_scrambler #(
    .USER_W (USER_W),
    .SCR_LEN(SCR_LEN),
    .SCR_TAP(SCR_TAP),
    .SEED   (SEED)
  ) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (word_en),
    .user_i({data_in, trig_in}),
    .scr_o (user_scr)
  );

  // split the user field: alternate symbols go to alternate codewords
  always_comb begin
    for (int c = 0; c < N_CW; c++) cw_msg[c] = '0;
    for (int j = 0; j < USER_SYM; j++)
      cw_msg[j % N_CW][(INFO_SYM - 1 - j / N_CW)*SYM_W +: SYM_W] =
        user_scr[(USER_SYM - 1 - j)*SYM_W +: SYM_W];
  end

  for (genvar g = 0; g < N_CW; g++) begin : g_cw
    rsenc_parity #(
      .INFO_SYM(INFO_SYM),
      .PAR_SYM (PAR_SYM)
    ) u_par (
      .msg_i(cw_msg[g]),
      .par_o(cw_par[g])
    );
  end

  // parity field: highest degree first, codewords alternating
  always_comb begin
    for (int q = 0; q < PAR_TOT; q++)
      par_field[(PAR_TOT - 1 - q)*SYM_W +: SYM_W] =
        cw_par[q % N_CW][(PAR_SYM - 1 - q / N_CW)*SYM_W +: SYM_W];
  end

  always_comb frame_d = {hdr_in, user_scr, par_field};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= word_en;
      if (word_en) frame_q <= frame_d;
    end
  end

  assign frame_out = frame_q;
  assign frame_vld = vld_q;

  p_valid_follows_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |=> frame_vld)
    else $error("frame_vld missing after enabled word");

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_en |=> !frame_vld)
    else $error("frame_vld high after idle cycle");

  p_header_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_en |=> (frame_out[FRAME_W-1 -: HDR_W] == $past(hdr_in)))
    else $error("header not carried unchanged");

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_en |=> $stable(frame_out))
    else $error("frame changed while idle");
endmodule

// File: tb/sim_rs_frame_encoder.sv
module sim_rs_frame_encoder;
  localparam logic [57:0] TB_SEED = 58'h2F0_1E2D_3C4B_5A69;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         word_en;
  logic [63:0]  data_in;
  logic [7:0]   trig_in;
  logic [3:0]   hdr_in;
  logic [107:0] frame_out;
  logic         frame_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [57:0]  bh;        // bench scrambler history
  logic [107:0] exp_frame; // expected header + user field (parity bits zero)

  always #4 clk = ~clk;

  rs_frame_encoder #(.SEED(TB_SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .word_en(word_en),
    .data_in(data_in), .trig_in(trig_in), .hdr_in(hdr_in),
    .frame_out(frame_out), .frame_vld(frame_vld)
  );

  task automatic check(input bit ok, input string req,
                       input logic [107:0] act, input logic [107:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] tb_mul(logic [3:0] a, logic [3:0] b);
    logic [6:0] p;
    p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (7'(a) << i);
    for (int i = 6; i >= 4; i--) if (p[i]) p = p ^ (7'b0010011 << (i - 4));
    return p[3:0];
  endfunction

  function automatic logic [3:0] tb_apow(int e);
    logic [3:0] r;
    r = 4'd1;
    for (int i = 0; i < e; i++) r = tb_mul(r, 4'd2);
    return r;
  endfunction

  function automatic logic [3:0] tb_syndrome(logic [107:0] f, int cw, int root);
    logic [3:0] s;
    logic [3:0] sym;
    s = '0;
    for (int d = 0; d <= 12; d++) begin
      if (d >= 4) sym = f[103 - 4*(2*(12 - d) + cw) -: 4];
      else        sym = f[31 - 4*(2*(3 - d) + cw) -: 4];
      s = s ^ tb_mul(sym, tb_apow(root * d));
    end
    return s;
  endfunction

  // expected scrambled user field, advancing the bench history
  task automatic model_word(input logic [63:0] d, input logic [7:0] t, input logic [3:0] h);
    logic [71:0] u;
    logic [71:0] s;
    u = {d, t};
    for (int b = 71; b >= 0; b--) begin
      s[b] = u[b] ^ bh[38] ^ bh[57];
      bh   = {bh[56:0], s[b]};
    end
    exp_frame = {h, s, 32'h0};
  endtask

  task automatic check_frame(input string tag);
    logic [7:0] syn_bad;
    check(frame_vld == 1'b1, {"R2 valid ", tag}, 108'(frame_vld), 108'd1);
    check(frame_out[107:104] == exp_frame[107:104], {"R3 header ", tag},
          108'(frame_out[107:104]), 108'(exp_frame[107:104]));
    check(frame_out[103:32] == exp_frame[103:32], {"R4 user field ", tag},
          108'(frame_out[103:32]), 108'(exp_frame[103:32]));
    syn_bad = '0;
    for (int c = 0; c < 2; c++)
      for (int r = 1; r <= 4; r++)
        if (tb_syndrome(frame_out, c, r) != 4'd0) syn_bad[c*4 + r - 1] = 1'b1;
    check(syn_bad == 8'd0, {"R5 R6 codeword roots ", tag}, 108'(syn_bad), 108'd0);
  endtask

  task automatic drive(input logic [63:0] d, input logic [7:0] t, input logic [3:0] h);
    data_in = d; trig_in = t; hdr_in = h; word_en = 1'b1;
    model_word(d, t, h);
  endtask

  task automatic send_one(input logic [63:0] d, input logic [7:0] t,
                          input logic [3:0] h, input string tag);
    @(negedge clk);
    drive(d, t, h);
    @(negedge clk);
    word_en = 1'b0;
    check_frame(tag);
  endtask

  task automatic t_reset_state();
    check(frame_out == '0, "R1 frame after reset", frame_out, '0);
    check(frame_vld == 1'b0, "R1 valid after reset", 108'(frame_vld), 108'd0);
  endtask

  task automatic t_zero_word();
    send_one(64'h0, 8'h00, 4'h5, "zero word");
  endtask

  task automatic t_patterns();
    send_one({64{1'b1}}, 8'hFF, 4'hA, "all ones");
    send_one(64'hA5A5_5A5A_0F0F_F0F0, 8'h3C, 4'hC, "alternating");
    send_one(64'h8000_0000_0000_0001, 8'h80, 4'h1, "edge bits");
  endtask

  task automatic t_burst();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) check_frame("burst");
      drive({$urandom, $urandom}, 8'($urandom), 4'(i));
    end
    @(negedge clk);
    word_en = 1'b0;
    check_frame("burst last");
  endtask

  task automatic t_idle();
    logic [107:0] held;
    send_one(64'h0123_4567_89AB_CDEF, 8'h5A, 4'h6, "before idle");
    held = frame_out;
    data_in = 64'hFFFF_0000_FFFF_0000; trig_in = 8'hE7; hdr_in = 4'hF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(frame_out == held, "R7 frame held while idle", frame_out, held);
      check(frame_vld == 1'b0, "R2 valid low while idle", 108'(frame_vld), 108'd0);
    end
    send_one(64'hDEAD_BEEF_0BAD_F00D, 8'h42, 4'h9, "R7 after idle");
  endtask

  task automatic t_mid_reset();
    send_one(64'h1111_2222_3333_4444, 8'h55, 4'h3, "before reset");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    bh = TB_SEED;
    @(negedge clk);
    t_reset_state();
    send_one(64'h1111_2222_3333_4444, 8'h55, 4'h3, "R8 restart");
  endtask

  initial begin
    rst_n = 1'b0; word_en = 1'b0;
    data_in = '0; trig_in = '0; hdr_in = '0;
    bh = TB_SEED;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_zero_word();
    t_patterns();
    t_burst();
    t_idle();
    t_mid_reset();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule